// File: doc/BRIEF.md
# BERT Receive Pattern Checker

This block checks a serial bit stream against a selectable test pattern and measures its bit error rate. A local reference shift register seeds itself from the received bits, so no knowledge of the far-end generator phase is needed. Once the reference predicts the stream without error for a run of bits, the block declares pattern sync. From then on, the reference runs on its own predicted bits, so a line error shows up as a single miscompare and does not propagate.

While in sync, the block counts every received bit and every miscompare in two saturating counters. A rising edge on the snapshot control copies both running counts into output registers and starts a new measurement period from zero. A rising edge on the resync control abandons sync and restarts acquisition. Repeated bursts of errors also drop sync on their own.

Top module: `bert_rx_checker`

## Requirements
- R1: Pattern select codes and generating recurrences, where b[n] = b[n-a] XOR b[n-b]: 000 uses (6,7), which is 2^7-1. 001 uses (9,11), which is 2^11-1. 010 uses (14,15), which is 2^15-1. 111 uses (5,9), which is 2^9-1. 011 uses (17,20), the 2^20-1 stream of R2. With a selected pattern locked, a clean stream gives zero counted errors.
- R2: For code 011 the line bit is s[n] OR z[n]. Here s follows the (17,20) recurrence, and z[n] is 1 when the 14 preceding s bits are all zero. The checker tracks such a stream through its forced-one stretches without miscompares.
- R3: Codes 100, 101 and 110 are not supported. With any of them selected, sync is never declared, and an existing sync is dropped.
- R4: When rx_inv_i is 1, each received bit is complemented before comparison. A complemented stream locks only with rx_inv_i set to 1.
- R5: Acquisition loads the reference from the received bits. Sync_o rises after exactly 32 consecutive enabled bits that match the reference prediction, and never earlier than 32 enabled bits after acquisition starts.
- R6: A match does not count toward sync while the reference history within the pattern length is all zero. An all-zero stream never gains sync.
- R7: In sync, bits are grouped in 64-bit blocks starting at the sync declaration. The 6th miscompare within one block drops sync and restarts acquisition. Five miscompares leave sync in place.
- R8: Bits and miscompares are counted only on enabled bits while sync_o is 1. Cycles with bit_en_i low change nothing.
- R9: A rising edge of cnt_latch_i copies the running bit and error counts to bit_cnt_o and err_cnt_o and clears the running counts. Otherwise both outputs hold, and both are zero after reset.
- R10: A rising edge of resync_i clears sync_o on the next cycle and restarts acquisition. Holding resync_i high has no further effect.
- R11: Both running counts saturate at all ones instead of wrapping.
- R12: While in sync, a single line error yields exactly one counted error. The reference is not disturbed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies rx_data_i as a bit this cycle |
| rx_data_i | input | 1 | Received serial data |
| pat_sel_i | input | 3 | Pattern select code |
| rx_inv_i | input | 1 | Complement received data |
| cnt_latch_i | input | 1 | Snapshot and clear counts on rising edge |
| resync_i | input | 1 | Force reacquisition on rising edge |
| sync_o | output | 1 | Pattern sync flag |
| bit_cnt_o | output | BIT_CNT_W (32) | Latched bit count |
| err_cnt_o | output | ERR_CNT_W (24) | Latched error count |

## Verification
The bound checker watches several rules on every cycle. It confirms that sync rises only on an enabled bit and falls after a resync edge. It confirms that the outputs hold between snapshot edges and that running counts move only on enabled in-sync bits. It also confirms that neither count wraps and that errors never exceed bits. The directed scenarios are the only place where these are shown: the exact 32-bit lock point, each pattern recurrence including the forced-one stretches of the 20-stage pattern, the 6-in-64 loss rule, inversion, unsupported codes and the all-zero stream. The same goes for the exact snapshot values, because the per-cycle checks cannot predict the stream.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

  localparam int REF_W  = 20;  // longest recurrence
  localparam int ZRUN_W = 14;  // zero run that forces a one

  typedef enum logic [2:0] {
    PAT_PN7     = 3'b000,
    PAT_PN11    = 3'b001,
    PAT_PN15    = 3'b010,
    PAT_PN20Z   = 3'b011,
    PAT_RSV_REP = 3'b100,
    PAT_RSV_ALT = 3'b101,
    PAT_RSV_OCT = 3'b110,
    PAT_PN9     = 3'b111
  } pat_e;

  typedef struct packed {
    logic       valid;
    logic       zsup;
    logic [4:0] tap_a;
    logic [4:0] tap_b;
  } pat_cfg_t;

  function automatic pat_cfg_t pat_cfg(input logic [2:0] sel);
    pat_cfg_t c;
    c = '{valid: 1'b1, zsup: 1'b0, tap_a: 5'd6, tap_b: 5'd7};
    case (pat_e'(sel))
      PAT_PN7:   begin c.tap_a = 5'd6;  c.tap_b = 5'd7;  end
      PAT_PN11:  begin c.tap_a = 5'd9;  c.tap_b = 5'd11; end
      PAT_PN15:  begin c.tap_a = 5'd14; c.tap_b = 5'd15; end
      PAT_PN20Z: begin c.tap_a = 5'd17; c.tap_b = 5'd20; c.zsup = 1'b1; end
      PAT_PN9:   begin c.tap_a = 5'd5;  c.tap_b = 5'd9;  end
      default:   c.valid = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bert_rx_edge.sv
module bert_rx_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ctrl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_i;

  assign rise_o = ctrl_i & ~ctrl_q;
endmodule

// File: rtl/bert_rx_ref.sv
module bert_rx_ref
  import bert_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       rx_bit_i,
  input  logic       track_i,
  input  logic       zsup_i,
  input  logic [4:0] tap_a_i,
  input  logic [4:0] tap_b_i,
  output logic       exp_bit_o,
  output logic       hist_zero_o
);
  logic [REF_W-1:0] hist_q;
  logic pa, pb, pred, zrun, shift_in, any_set;

  always_comb begin
    pa = 1'b0;
    pb = 1'b0;
    any_set = 1'b0;
    for (int i = 0; i < REF_W; i++) begin
      if (5'(i + 1) == tap_a_i) pa = hist_q[i];
      if (5'(i + 1) == tap_b_i) pb = hist_q[i];
      if (5'(i) < tap_b_i)      any_set = any_set | hist_q[i];
    end
  end

  assign pred        = pa ^ pb;
  assign zrun        = zsup_i && (hist_q[ZRUN_W-1:0] == '0);
  assign exp_bit_o   = pred | zrun;
  assign hist_zero_o = !any_set;
  // free-run on prediction when locked or when the line bit is a forced one
  assign shift_in    = (track_i || zrun) ? pred : rx_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       hist_q <= '0;
    else if (bit_en_i) hist_q <= {hist_q[REF_W-2:0], shift_in};
endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync #(
  parameter int MATCH_N = 32,
  parameter int WIN_LEN = 64,
  parameter int LOSS_N  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic miss_i,
  input  logic block_i,
  input  logic valid_i,
  input  logic restart_i,
  output logic sync_o
);
  localparam int MW = $clog2(MATCH_N);
  localparam int WW = $clog2(WIN_LEN);
  localparam int EW = $clog2(LOSS_N);

  logic          sync_q;
  logic [MW-1:0] match_q;
  logic [WW-1:0] win_q;
  logic [EW-1:0] werr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b0;
      match_q <= '0;
      win_q   <= '0;
      werr_q  <= '0;
    end else if (restart_i || (sync_q && !valid_i)) begin
      sync_q  <= 1'b0;
      match_q <= '0;
    end else if (bit_en_i) begin
      if (!sync_q) begin
        if (miss_i || block_i || !valid_i) begin
          match_q <= '0;
        end else if (match_q == MW'(MATCH_N - 1)) begin
          sync_q  <= 1'b1;
          match_q <= '0;
          win_q   <= '0;
          werr_q  <= '0;
        end else begin
          match_q <= match_q + 1'b1;
        end
      end else if (miss_i && (werr_q == EW'(LOSS_N - 1))) begin
        sync_q <= 1'b0;
      end else if (win_q == WW'(WIN_LEN - 1)) begin
        win_q  <= '0;
        werr_q <= '0;
      end else begin
        win_q  <= win_q + 1'b1;
        werr_q <= werr_q + EW'(miss_i);
      end
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/bert_rx_satcnt.sv
module bert_rx_satcnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, base, nxt;

  always_comb begin
    base = clr_i ? '0 : cnt_q;
    nxt  = (inc_i && !(&base)) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt;

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker
  import bert_rx_pkg::*;
#(
  parameter int BIT_CNT_W = 32,
  parameter int ERR_CNT_W = 24,
  parameter int MATCH_N   = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_N    = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_en_i,
  input  logic                 rx_data_i,
  input  logic [2:0]           pat_sel_i,
  input  logic                 rx_inv_i,
  input  logic                 cnt_latch_i,
  input  logic                 resync_i,
  output logic                 sync_o,
  output logic [BIT_CNT_W-1:0] bit_cnt_o,
  output logic [ERR_CNT_W-1:0] err_cnt_o
);
  localparam int N_CTRL = 2;

  logic [N_CTRL-1:0]    ctrl_rise;
  logic                 latch_pulse, resync_pulse;
  logic                 rx_bit, exp_bit, hist_zero, miss, sync_q, count_en;
  pat_cfg_t             cfg;
  logic [BIT_CNT_W-1:0] bit_run;
  logic [ERR_CNT_W-1:0] err_run;

  bert_rx_edge #(.N(N_CTRL)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i ({resync_i, cnt_latch_i}),
    .rise_o (ctrl_rise)
  );
  assign latch_pulse  = ctrl_rise[0];
  assign resync_pulse = ctrl_rise[1];

  assign cfg    = pat_cfg(pat_sel_i);
  assign rx_bit = rx_data_i ^ rx_inv_i;

  bert_rx_ref u_ref (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .rx_bit_i    (rx_bit),
    .track_i     (sync_q),
    .zsup_i      (cfg.zsup),
    .tap_a_i     (cfg.tap_a),
    .tap_b_i     (cfg.tap_b),
    .exp_bit_o   (exp_bit),
    .hist_zero_o (hist_zero)
  );

  assign miss = rx_bit ^ exp_bit;

  bert_rx_sync #(
    .MATCH_N (MATCH_N),
    .WIN_LEN (WIN_LEN),
    .LOSS_N  (LOSS_N)
  ) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .miss_i    (miss),
    .block_i   (hist_zero),
    .valid_i   (cfg.valid),
    .restart_i (resync_pulse),
    .sync_o    (sync_q)
  );

  assign count_en = bit_en_i & sync_q;

  bert_rx_satcnt #(.W(BIT_CNT_W)) u_bit_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (latch_pulse),
    .inc_i  (count_en),
    .cnt_o  (bit_run)
  );

  bert_rx_satcnt #(.W(ERR_CNT_W)) u_err_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (latch_pulse),
    .inc_i  (count_en & miss),
    .cnt_o  (err_run)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bit_cnt_o <= '0;
      err_cnt_o <= '0;
    end else if (latch_pulse) begin
      bit_cnt_o <= bit_run;
      err_cnt_o <= err_run;
    end

  assign sync_o = sync_q;
endmodule

// File: rtl/bert_rx_checker_sva.sv
module bert_rx_checker_sva #(
  parameter int BIT_CNT_W = 32,
  parameter int ERR_CNT_W = 24
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bit_en_i,
  input logic                 sync_o,
  input logic                 latch_pulse,
  input logic                 resync_pulse,
  input logic [BIT_CNT_W-1:0] bit_cnt_o,
  input logic [ERR_CNT_W-1:0] err_cnt_o,
  input logic [BIT_CNT_W-1:0] bit_run,
  input logic [ERR_CNT_W-1:0] err_run
);
  localparam int CMP_W = (BIT_CNT_W > ERR_CNT_W) ? BIT_CNT_W : ERR_CNT_W;

  a_r5_rise_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> ($past(bit_en_i) && !$past(resync_pulse)));

  a_r10_resync_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_pulse |=> !sync_o);

  a_r9_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_pulse |=> ($stable(bit_cnt_o) && $stable(err_cnt_o)));

  a_r9_latch_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_pulse |=> (bit_run <= BIT_CNT_W'(1) && err_run <= ERR_CNT_W'(1)));

  a_r8_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && !latch_pulse) |=> ($stable(bit_run) && $stable(err_run)));

  a_r8_unsynced_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_o && !latch_pulse) |=> ($stable(bit_run) && $stable(err_run)));

  a_r11_bits_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&bit_run) && !latch_pulse) |=> (&bit_run));

  a_r11_errs_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&err_run) && !latch_pulse) |=> (&err_run));

  a_r8_errs_within_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CMP_W'(err_run) <= CMP_W'(bit_run)) || (&bit_run));
endmodule

bind bert_rx_checker bert_rx_checker_sva #(
  .BIT_CNT_W (BIT_CNT_W),
  .ERR_CNT_W (ERR_CNT_W)
) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_en_i     (bit_en_i),
  .sync_o       (sync_o),
  .latch_pulse  (latch_pulse),
  .resync_pulse (resync_pulse),
  .bit_cnt_o    (bit_cnt_o),
  .err_cnt_o    (err_cnt_o),
  .bit_run      (bit_run),
  .err_run      (err_run)
);

// File: tb/test_bert_rx_checker.sv
module test_bert_rx_checker;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] SEED = 20'hACE1B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, rx_data = 1'b0, rx_inv = 1'b0;
  logic        cnt_latch = 1'b0, resync = 1'b0;
  logic [2:0]  pat_sel = 3'b000;
  logic        sync, sync_s;
  logic [31:0] bit_cnt;
  logic [23:0] err_cnt;
  logic [5:0]  bit_cnt_s;
  logic [1:0]  err_cnt_s;

  int n_vec = 0, n_bad = 0;
  logic [19:0] gen_h;
  logic [2:0]  gen_sel;
  logic        gen_inv = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bert_rx_checker i_bert_rx_checker (
    .clk_i (clk), .rst_ni (rst_n), .bit_en_i (bit_en), .rx_data_i (rx_data),
    .pat_sel_i (pat_sel), .rx_inv_i (rx_inv), .cnt_latch_i (cnt_latch),
    .resync_i (resync), .sync_o (sync), .bit_cnt_o (bit_cnt), .err_cnt_o (err_cnt)
  );

  bert_rx_checker #(.BIT_CNT_W(6), .ERR_CNT_W(2)) i_bert_rx_checker_sat (
    .clk_i (clk), .rst_ni (rst_n), .bit_en_i (bit_en), .rx_data_i (rx_data),
    .pat_sel_i (pat_sel), .rx_inv_i (rx_inv), .cnt_latch_i (cnt_latch),
    .resync_i (resync), .sync_o (sync_s), .bit_cnt_o (bit_cnt_s), .err_cnt_o (err_cnt_s)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic gen_bit(output logic t);
    int a, b;
    logic s;
    case (gen_sel)
      3'b000:  begin a = 6;  b = 7;  end
      3'b001:  begin a = 9;  b = 11; end
      3'b010:  begin a = 14; b = 15; end
      3'b011:  begin a = 17; b = 20; end
      default: begin a = 5;  b = 9;  end
    endcase
    s = gen_h[a-1] ^ gen_h[b-1];
    t = s | ((gen_sel == 3'b011) && (gen_h[13:0] == 14'd0));
    gen_h = {gen_h[18:0], s};
  endtask

  function automatic logic [19:0] back_steps(input logic [19:0] h, input int n);
    logic [19:0] v = h;
    for (int i = 0; i < n; i++) v = {v[0] ^ v[17], v[19:1]};
    return v;
  endfunction

  task automatic idle();
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic feed(input int n, input int flip_from = -1, input int flip_n = 0);
    logic b;
    for (int i = 0; i < n; i++) begin
      gen_bit(b);
      if (i >= flip_from && i < flip_from + flip_n) b = ~b;
      @(negedge clk);
      bit_en  = 1'b1;
      rx_data = b ^ gen_inv;
    end
    idle();
  endtask

  task automatic pulse_latch();
    @(negedge clk) cnt_latch = 1'b1;
    @(negedge clk) cnt_latch = 1'b0;
  endtask

  task automatic pulse_resync();
    @(negedge clk) resync = 1'b1;
    @(negedge clk) resync = 1'b0;
  endtask

  task automatic start_pattern(input logic [2:0] sel, input logic [19:0] seed);
    pat_sel = sel;
    gen_sel = sel;
    gen_h   = seed;
    pulse_resync();
  endtask

  task automatic t_reset();
    chk("R9 reset sync", sync, 0);
    chk("R9 reset bit count", bit_cnt, 0);
    chk("R9 reset err count", err_cnt, 0);
  endtask

  task automatic t_patterns();
    logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b111, 3'b011};
    foreach (codes[k]) begin
      start_pattern(codes[k], (codes[k] == 3'b011) ? back_steps(20'h00001, 300) : SEED);
      feed(100);
      chk($sformatf("R1 lock code %0d", codes[k]), sync, 1);
      pulse_latch();
      feed(300);
      pulse_latch();
      chk($sformatf("R1 R2 clean bits code %0d", codes[k]), bit_cnt, 300);
      chk($sformatf("R1 R2 clean errs code %0d", codes[k]), err_cnt, 0);
    end
  endtask

  task automatic t_acq_timing();
    start_pattern(3'b000, SEED);
    feed(100);
    pulse_resync();
    chk("R10 resync edge drops", sync, 0);
    feed(31);
    chk("R5 no sync at 31", sync, 0);
    feed(1);
    chk("R5 sync at 32", sync, 1);
  endtask

  task automatic t_resync_level();
    @(negedge clk) resync = 1'b1;
    @(negedge clk);
    chk("R10 edge while held", sync, 0);
    feed(60);
    chk("R10 held level relocks", sync, 1);
    resync = 1'b0;
  endtask

  task automatic t_counting();
    pulse_latch();
    feed(100, 50, 1);
    pulse_latch();
    chk("R12 bits", bit_cnt, 100);
    chk("R12 single error", err_cnt, 1);
    chk("R11 small bits saturate", bit_cnt_s, 63);
    for (int i = 0; i < 20; i++) @(negedge clk) rx_data = ~rx_data;
    pulse_latch();
    chk("R8 idle bits", bit_cnt, 0);
    chk("R8 idle errs", err_cnt, 0);
    feed(10);
    chk("R9 hold without edge", bit_cnt, 0);
    pulse_latch();
    chk("R9 snapshot", bit_cnt, 10);
  endtask

  task automatic t_saturation();
    pulse_latch();
    feed(100, 10, 5);
    pulse_latch();
    chk("R7 five errors keep sync", sync, 1);
    chk("R7 five errors counted", err_cnt, 5);
    chk("R11 small errs saturate", err_cnt_s, 3);
    chk("R11 small bits saturate", bit_cnt_s, 63);
  endtask

  task automatic t_loss();
    feed(40, 0, 12);
    chk("R7 error burst drops sync", sync, 0);
    feed(100);
    chk("R7 reacquire", sync, 1);
  endtask

  task automatic t_invert();
    gen_inv = 1'b1;
    start_pattern(3'b000, SEED);
    feed(200);
    chk("R4 inverted without rx_inv", sync, 0);
    rx_inv = 1'b1;
    pulse_resync();
    feed(100);
    chk("R4 inverted with rx_inv", sync, 1);
    rx_inv  = 1'b0;
    gen_inv = 1'b0;
  endtask

  task automatic t_unsupported();
    logic [2:0] codes [3] = '{3'b100, 3'b101, 3'b110};
    foreach (codes[k]) begin
      start_pattern(3'b000, SEED);
      pat_sel = codes[k];
      feed(200);
      chk($sformatf("R3 no sync code %0d", codes[k]), sync, 0);
    end
  endtask

  task automatic t_zero();
    start_pattern(3'b000, SEED);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      bit_en  = 1'b1;
      rx_data = 1'b0;
    end
    idle();
    chk("R6 all-zero stream", sync, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_acq_timing();
    t_resync_level();
    t_counting();
    t_saturation();
    t_loss();
    t_invert();
    t_unsupported();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule